// File: doc/BRIEF.md
# Field-Manipulating Barrel Shifter

This unit is a single-cycle shifter datapath for 32-bit words. Each accepted operation names an opcode, a primary operand, a secondary operand that supplies deposit data, a signed shift count and a bit position/length pair. One clock later it returns a 32-bit result, a zero indication and a bit-test indication. A result can be fed back as an operand on the very next cycle.

The operation set covers logical and arithmetic shifts and rotation by a signed count. It also covers setting, clearing, toggling and testing one bit, and pulling a bit-field out of a word, right-justified and optionally sign-extended. A bit-field can be written into a word with the surrounding bits left intact. The last operation counts how many leading bits merely repeat the sign bit, which is the exponent adjustment that normalization needs.

Top module: `fieldshift_unit`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly one clock. `result`, `zero_flag` and `test_flag` change only in the cycle after an accepted operation and hold otherwise. A synchronous reset clears all four outputs to 0.
- R2: Opcode 0 (logical shift) treats `amount` as a signed 8-bit count. A count at or above zero shifts left, a negative count shifts right by its magnitude, and zeros fill the vacated bits. A magnitude of 32 or more gives 0.
- R3: Opcode 1 (arithmetic shift) shifts left like opcode 0. For a negative count it shifts right and fills with copies of bit 31. A right magnitude of 32 or more gives 32 copies of bit 31.
- R4: Opcode 2 (rotate) rotates `opnd_a` by the count's magnitude modulo 32. It rotates left for a count at or above zero and right for a negative count.
- R5: Opcodes 3, 4 and 5 set, clear and toggle, respectively, bit `fld_pos` of `opnd_a`. All other bits are unchanged.
- R6: Opcode 6 (bit test) returns `opnd_a` unchanged and sets `test_flag` to bit `fld_pos` of `opnd_a`. `test_flag` is 0 after every other opcode.
- R7: Opcode 7 (extract) returns the `fld_len` bits of `opnd_a` starting at bit `fld_pos`, right-justified, with zeros above them. A length above 32 acts as 32. Field bits beyond bit 31 read as 0. A length of 0 gives 0.
- R8: When `fld_sext` is 1, an extract with a length of 1 to 31 fills every bit above the field with the field's top bit.
- R9: Opcode 8 (deposit) copies the low `fld_len` bits of `opnd_b` into `opnd_a` starting at bit `fld_pos`. A length above 32 acts as 32, field bits beyond bit 31 are dropped, and all other bits of `opnd_a` are kept.
- R10: Opcode 9 (exponent) returns the number of bits below bit 31 that equal bit 31 before the first differing one. The value runs from 0 to 31, and it is 31 for all-zeros and all-ones.
- R11: `zero_flag` is 1 exactly when the registered `result` is all zeros.
- R12: Opcodes 10 to 15 return `opnd_a` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted this cycle |
| op | input | 4 | Opcode |
| opnd_a | input | 32 | Primary operand / destination |
| opnd_b | input | 32 | Deposit source |
| amount | input | 8 | Signed shift/rotate count |
| fld_pos | input | 5 | Bit position / field start |
| fld_len | input | 6 | Field length |
| fld_sext | input | 1 | Sign-extend extracted field |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Registered result |
| zero_flag | output | 1 | Result is zero |
| test_flag | output | 1 | Tested bit value |

## Verification
Shifts are tried with counts on both sides of zero and at 31, 32, 33 and -128. This separates direction handling, the saturation at the word width, and the difference between modulo rotation and a saturating shift. Sign-bit and single-bit operands separate the arithmetic fill from the zero fill. For extract and deposit, fields that run off the top of the word, zero-length fields and fields longer than 32 bits show the clamping and truncation rules. Exponent inputs with runs of sign copies of several lengths, of either polarity, pin the count. A long stream of random operations, some using the previous result as an operand, is compared with a behavioural model on every operation.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  typedef enum logic [3:0] {
    OP_LSH  = 4'd0,
    OP_ASH  = 4'd1,
    OP_ROT  = 4'd2,
    OP_BSET = 4'd3,
    OP_BCLR = 4'd4,
    OP_BTGL = 4'd5,
    OP_BTST = 4'd6,
    OP_FEXT = 4'd7,
    OP_FDEP = 4'd8,
    OP_EXPO = 4'd9
  } fsh_op_e;
endpackage

// File: rtl/fsh_barrel.sv
// Log-stage right shifter; each stage either rotates or fills.
module fsh_barrel #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          fill,
  input  logic          rot,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [0:SW];
  assign stg[0] = din;

  for (genvar i = 0; i < SW; i++) begin : g_stage
    localparam int D = 1 << i;
    logic [D-1:0] inb;
    assign inb        = rot ? stg[i][D-1:0] : {D{fill}};
    assign stg[i+1]   = amt[i] ? {inb, stg[i][W-1:D]} : stg[i];
  end

  assign dout = stg[SW];
endmodule

// File: rtl/fsh_shifter.sv
// Signed-count shift/rotate; left shifts reuse the right shifter via bit reversal.
module fsh_shifter #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic [W-1:0]  a,
  input  logic [AW-1:0] amount,
  input  logic          arith,
  input  logic          rot,
  output logic [W-1:0]  y
);
  localparam int SW = $clog2(W);
  localparam logic [AW-1:0] WLIM = AW'(W);

  function automatic logic [W-1:0] bitrev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  logic          left;
  logic [AW-1:0] mag;
  logic          big;
  logic          fill;
  logic [W-1:0]  bin, bout, shaped;

  assign left   = ~amount[AW-1];
  assign mag    = left ? amount : (~amount + 1'b1);
  assign big    = (mag >= WLIM);
  assign fill   = arith & ~left & a[W-1];
  assign bin    = left ? bitrev(a) : a;

  fsh_barrel #(.W(W), .SW(SW)) u_barrel (
    .din (bin),
    .amt (mag[SW-1:0]),
    .fill(fill),
    .rot (rot),
    .dout(bout)
  );

  assign shaped = left ? bitrev(bout) : bout;
  assign y      = (big && !rot) ? {W{fill}} : shaped;
endmodule

// File: rtl/fsh_field.sv
// Single-bit and bit-field operations.
module fsh_field #(
  parameter int W  = 32,
  parameter int PW = $clog2(W),
  parameter int LW = PW + 1
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [PW-1:0] pos,
  input  logic [LW-1:0] len,
  input  logic          sext,
  output logic [W-1:0]  ext_y,
  output logic [W-1:0]  dep_y,
  output logic [W-1:0]  set_y,
  output logic [W-1:0]  clr_y,
  output logic [W-1:0]  tgl_y,
  output logic          tbit
);
  localparam logic [LW-1:0] LMAX = LW'(W);

  logic [LW-1:0] len_c;
  logic [W:0]    wide_mask;
  logic [W-1:0]  low_mask, ext_raw, dmask, bmask;
  logic [PW-1:0] top_idx;
  logic          sbit;

  assign len_c     = (len > LMAX) ? LMAX : len;
  assign wide_mask = ({{W{1'b0}}, 1'b1} << len_c) - 1'b1;
  assign low_mask  = wide_mask[W-1:0];
  assign ext_raw   = (a >> pos) & low_mask;
  assign top_idx   = PW'(len_c - 1'b1);
  assign sbit      = (len_c != '0) && ext_raw[top_idx];
  assign ext_y     = (sext && sbit) ? (ext_raw | ~low_mask) : ext_raw;

  assign dmask     = low_mask << pos;
  assign dep_y     = (a & ~dmask) | ((b << pos) & dmask);

  assign bmask     = {{(W-1){1'b0}}, 1'b1} << pos;
  assign set_y     = a | bmask;
  assign clr_y     = a & ~bmask;
  assign tgl_y     = a ^ bmask;
  assign tbit      = a[pos];
endmodule

// File: rtl/fsh_expo.sv
// Counts bits below the MSB that repeat the MSB before the first change.
module fsh_expo #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  output logic [CW-1:0] cnt
);
  always_comb begin
    logic hit;
    hit = 1'b0;
    cnt = '0;
    for (int i = W - 2; i >= 0; i--) begin
      if (!hit) begin
        if (a[i] == a[W-1]) cnt = cnt + 1'b1;
        else                hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fieldshift_unit.sv
module fieldshift_unit #(
  parameter int W  = 32,
  parameter int AW = 8,
  parameter int PW = $clog2(W),
  parameter int LW = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic [AW-1:0] amount,
  input  logic [PW-1:0] fld_pos,
  input  logic [LW-1:0] fld_len,
  input  logic          fld_sext,
  output logic          out_valid,
  output logic [W-1:0]  result,
  output logic          zero_flag,
  output logic          test_flag
);
  import fsh_pkg::*;

  localparam int CW = $clog2(W);

  fsh_op_e      opc;
  logic [W-1:0] sh_y, ext_y, dep_y, set_y, clr_y, tgl_y, nxt;
  logic [CW-1:0] ex_cnt;
  logic          tbit, nxt_t;

  assign opc = fsh_op_e'(op);

  fsh_shifter #(.W(W), .AW(AW)) u_shift (
    .a     (opnd_a),
    .amount(amount),
    .arith (opc == OP_ASH),
    .rot   (opc == OP_ROT),
    .y     (sh_y)
  );

  fsh_field #(.W(W), .PW(PW), .LW(LW)) u_field (
    .a    (opnd_a),
    .b    (opnd_b),
    .pos  (fld_pos),
    .len  (fld_len),
    .sext (fld_sext),
    .ext_y(ext_y),
    .dep_y(dep_y),
    .set_y(set_y),
    .clr_y(clr_y),
    .tgl_y(tgl_y),
    .tbit (tbit)
  );

  fsh_expo #(.W(W), .CW(CW)) u_expo (
    .a  (opnd_a),
    .cnt(ex_cnt)
  );

  always_comb begin
    nxt   = opnd_a;
    nxt_t = 1'b0;
    unique case (opc)
      OP_LSH, OP_ASH, OP_ROT: nxt = sh_y;
      OP_BSET: nxt = set_y;
      OP_BCLR: nxt = clr_y;
      OP_BTGL: nxt = tgl_y;
      OP_BTST: nxt_t = tbit;
      OP_FEXT: nxt = ext_y;
      OP_FDEP: nxt = dep_y;
      OP_EXPO: nxt = {{(W-CW){1'b0}}, ex_cnt};
      default: nxt = opnd_a;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      zero_flag <= 1'b0;
      test_flag <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt;
        zero_flag <= (nxt == '0);
        test_flag <= nxt_t;
      end
    end
  end
endmodule

// File: rtl/fieldshift_unit_chk.sv
module fieldshift_unit_chk #(
  parameter int W  = 32,
  parameter int AW = 8,
  parameter int PW = $clog2(W),
  parameter int LW = PW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [3:0]    op,
  input logic [W-1:0]  opnd_a,
  input logic          out_valid,
  input logic [W-1:0]  result,
  input logic          zero_flag,
  input logic          test_flag
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_follows_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_result_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result) && $stable(zero_flag) && $stable(test_flag));
  assert_rot_keeps_ones_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd2) |=> $countones(result) == $countones($past(opnd_a)));
  assert_btst_keeps_word_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd6) |=> result == $past(opnd_a));
  assert_tflag_only_btst_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op != 4'd6) |=> !test_flag);
  assert_expo_range_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd9) |=> result <= W - 1);
  assert_zero_flag_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (zero_flag == (result == '0)));
  assert_reserved_pass_R12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 4'd10) |=> result == $past(opnd_a));
endmodule

bind fieldshift_unit fieldshift_unit_chk #(.W(W), .AW(AW), .PW(PW), .LW(LW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .op       (op),
  .opnd_a   (opnd_a),
  .out_valid(out_valid),
  .result   (result),
  .zero_flag(zero_flag),
  .test_flag(test_flag)
);

// File: tb/fieldshift_unit_test.sv
`timescale 1ns/1ps
module fieldshift_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [7:0]  amount = '0;
  logic [4:0]  fld_pos = '0;
  logic [5:0]  fld_len = '0;
  logic        fld_sext = 1'b0;
  logic        out_valid, zero_flag, test_flag;
  logic [31:0] result;

  int errors = 0;
  int checks = 0;
  logic [31:0] last_res = '0;

  always #2 clk = ~clk;

  fieldshift_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .amount(amount),
    .fld_pos(fld_pos), .fld_len(fld_len), .fld_sext(fld_sext),
    .out_valid(out_valid), .result(result),
    .zero_flag(zero_flag), .test_flag(test_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input int o, input bit sx);
    case (o)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4, 5: return "R5";
      6: return "R6";
      7: return sx ? "R8" : "R7";
      8: return "R9";
      9: return "R10";
      default: return "R12";
    endcase
  endfunction

  // Behavioural reference: {test bit, result}
  function automatic logic [32:0] model(input int o, input logic [31:0] a, input logic [31:0] b,
                                        input logic [7:0] amt, input int p, input int ln, input bit sx);
    logic [31:0] r;
    logic t;
    int am, m, k, lc;
    r = a; t = 1'b0;
    am = int'($signed(amt));
    m  = (am < 0) ? -am : am;
    lc = (ln > 32) ? 32 : ln;
    case (o)
      0, 1: begin
        for (int i = 0; i < 32; i++) begin
          if (am >= 0) r[i] = (i - m >= 0) ? a[i-m] : 1'b0;
          else r[i] = (i + m < 32) ? a[i+m] : ((o == 1) ? a[31] : 1'b0);
        end
      end
      2: begin
        k = m % 32;
        for (int i = 0; i < 32; i++) begin
          if (am >= 0) r[(i + k) % 32] = a[i];
          else r[i] = a[(i + k) % 32];
        end
      end
      3: r[p] = 1'b1;
      4: r[p] = 1'b0;
      5: r[p] = ~a[p];
      6: t = a[p];
      7: begin
        r = '0;
        for (int i = 0; i < lc; i++) r[i] = (p + i < 32) ? a[p+i] : 1'b0;
        if (sx && lc > 0 && lc < 32)
          for (int i = lc; i < 32; i++) r[i] = r[lc-1];
      end
      8: for (int i = 0; i < lc; i++) if (p + i < 32) r[p+i] = b[i];
      9: begin
        k = 0;
        for (int i = 30; i >= 0; i--) begin
          if (a[i] != a[31]) break;
          k++;
        end
        r = 32'(k);
      end
      default: r = a;
    endcase
    return {t, r};
  endfunction

  task automatic run_op(input int o, input logic [31:0] a, input logic [31:0] b,
                        input logic [7:0] amt, input int p, input int ln, input bit sx);
    logic [32:0] e;
    string rq;
    @(negedge clk);
    op = 4'(o); opnd_a = a; opnd_b = b; amount = amt;
    fld_pos = 5'(p); fld_len = 6'(ln); fld_sext = sx; in_valid = 1'b1;
    e  = model(o, a, b, amt, p, ln, sx);
    rq = req_of(o, sx);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R1", 64'(out_valid), 64'd1);
    chk(result == e[31:0], rq, 64'(result), 64'(e[31:0]));
    chk(test_flag == e[32], "R6", 64'(test_flag), 64'(e[32]));
    chk(zero_flag == (e[31:0] == 0), "R11", 64'(zero_flag), 64'(e[31:0] == 0));
    last_res = result;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog act=%h exp=%h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 0 && result == 0 && zero_flag == 0 && test_flag == 0, "R1",
        {out_valid, zero_flag, test_flag, result}, 64'd0);
    rst = 1'b0;
    // R2 logical shifts
    run_op(0, 32'h8000_0001, 0, 8'd4, 0, 0, 0);
    run_op(0, 32'h8000_0001, 0, -8'sd4, 0, 0, 0);
    run_op(0, 32'h8000_0001, 0, 8'd31, 0, 0, 0);
    run_op(0, 32'hFFFF_FFFF, 0, 8'd32, 0, 0, 0);
    run_op(0, 32'hFFFF_FFFF, 0, 8'h80, 0, 0, 0);
    // R3 arithmetic shifts
    run_op(1, 32'h8000_0000, 0, -8'sd4, 0, 0, 0);
    run_op(1, 32'h8000_0000, 0, -8'sd40, 0, 0, 0);
    run_op(1, 32'h7000_0000, 0, -8'sd40, 0, 0, 0);
    run_op(1, 32'h4000_0000, 0, 8'd1, 0, 0, 0);
    // R4 rotate
    run_op(2, 32'h8000_0001, 0, 8'd1, 0, 0, 0);
    run_op(2, 32'h8000_0001, 0, -8'sd1, 0, 0, 0);
    run_op(2, 32'h8000_0001, 0, 8'd33, 0, 0, 0);
    run_op(2, 32'h1234_5678, 0, 8'd32, 0, 0, 0);
    // R5 bit ops
    run_op(3, 32'h0, 0, 0, 31, 0, 0);
    run_op(4, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    run_op(5, 32'h0000_0010, 0, 0, 4, 0, 0);
    // R6 bit test
    run_op(6, 32'h0000_0100, 0, 0, 8, 0, 0);
    run_op(6, 32'h0000_0100, 0, 0, 9, 0, 0);
    // R7/R8 extract
    run_op(7, 32'h1234_5678, 0, 0, 8, 8, 0);
    run_op(7, 32'h0000_F000, 0, 0, 12, 4, 1);
    run_op(7, 32'hF000_0000, 0, 0, 28, 8, 0);
    run_op(7, 32'hF000_0000, 0, 0, 28, 8, 1);
    run_op(7, 32'hFFFF_FFFF, 0, 0, 3, 0, 1);
    run_op(7, 32'hDEAD_BEEF, 0, 0, 0, 63, 1);
    // R9 deposit
    run_op(8, 32'hFFFF_FFFF, 32'h0, 0, 4, 8, 0);
    run_op(8, 32'h0000_0000, 32'hFF, 0, 28, 8, 0);
    run_op(8, 32'h1234_5678, 32'hCAFE_F00D, 0, 0, 40, 0);
    run_op(8, 32'h1234_5678, 32'hCAFE_F00D, 0, 5, 0, 0);
    // R10 exponent
    run_op(9, 32'h0, 0, 0, 0, 0, 0);
    run_op(9, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    run_op(9, 32'h4000_0000, 0, 0, 0, 0, 0);
    run_op(9, 32'h0001_0000, 0, 0, 0, 0, 0);
    run_op(9, 32'hFFFF_0000, 0, 0, 0, 0, 0);
    run_op(9, 32'h8000_0000, 0, 0, 0, 0, 0);
    // R12 reserved opcodes
    run_op(12, 32'hA5A5_5A5A, 0, 0, 0, 0, 0);
    run_op(15, 32'h0, 0, 0, 0, 0, 0);
    // R1 hold: idle cycle with new inputs must not change outputs
    begin
      logic [31:0] held;
      held = result;
      @(negedge clk);
      op = 4'd3; opnd_a = 32'h0; fld_pos = 5'd7; in_valid = 1'b0;
      @(negedge clk);
      chk(out_valid == 0, "R1", 64'(out_valid), 64'd0);
      chk(result == held, "R1", 64'(result), 64'(held));
    end
    // Random stream, half the time chaining the previous result
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a;
      a = ($urandom % 2) ? last_res : $urandom;
      if ($urandom % 4 == 0) a = 32'($signed(a) >>> ($urandom % 32));
      run_op(int'($urandom % 16), a, $urandom, 8'($urandom),
             int'($urandom % 32), int'($urandom % 64), bit'($urandom % 2));
    end
    // R1: reset again clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 0 && result == 0 && zero_flag == 0 && test_flag == 0, "R1",
        {out_valid, zero_flag, test_flag, result}, 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule